// File: doc/BRIEF.md
# Per-Channel Parity Interrupt Aggregator

This block gathers alarm events from a bank of input channels into one active-low interrupt line. Each channel owns one status word on a small synchronous register bus. The word holds sticky flags for parity errors, out-of-frame alarms and loss-of-signal alarms. It also holds a provisioning bit and one interrupt mask per alarm type. Events arrive as single-cycle pulses. They set the matching sticky flag whatever the configuration. Configuration only decides whether a pending flag may pull the interrupt line low.

No register reports which channel raised the interrupt. Software reacts to a low interrupt by reading every channel word in turn. Each read returns the word and clears that channel's sticky flags. Once every pending, enabled flag has been read out, the line goes high again. Writes can change only the configuration bits, so software can never clear or fake an alarm by writing.

Top module: `par_irq_agg`

## Requirements
- R1: After reset all sticky flags, provisioning bits and parity masks are 0, the out-of-frame and loss-of-signal masks are 1, and `irq_n` is 1. A channel word therefore reads 0x18.
- R2: An event pulse sets that channel's sticky flag: parity sets bit 0, out-of-frame sets bit 5 and loss-of-signal sets bit 6. The flag holds until it is read.
- R3: A flag that is set, on a provisioned channel (bit 1 = 1) with its mask clear, drives `irq_n` low one clock after the flag sets. That is two clocks after the event pulse.
- R4: A read (`rd_en` with `addr`) presents the channel word on `rd_data` one clock later. In that same edge it clears all three sticky flags of the channel.
- R5: A write (`wr_en`) loads bits 1 to 4 of `wr_data` into the provisioning and mask bits. It never changes a sticky flag, whether `wr_data` carries a 0 or a 1 in a flag position.
- R6: With the parity mask (bit 2) set to 1, a parity flag on that channel never pulls `irq_n` low.
- R7: A channel whose provisioning bit is 0 never pulls `irq_n` low, whatever its flags and masks.
- R8: The out-of-frame mask (bit 3) and the loss-of-signal mask (bit 4) each stop their own alarm flag from pulling `irq_n` low. Clearing a mask lets that flag interrupt.
- R9: Reading the channel that caused the interrupt returns `irq_n` to 1 one clock after the read edge, but only if no other enabled flag is still pending.
- R10: When an event arrives in the same cycle as a read of that channel, the read returns the old word and the flag ends up set.
- R11: With several channels pending, a read of every channel address restores `irq_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_evt | input | N_CH | Per-channel parity error pulses |
| oof_evt | input | N_CH | Per-channel out-of-frame pulses |
| los_evt | input | N_CH | Per-channel loss-of-signal pulses |
| addr | input | ADDR_W | Channel word address |
| rd_en | input | 1 | Read strobe; clears the addressed flags |
| wr_en | input | 1 | Write strobe for configuration bits |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low aggregated interrupt |

## Verification
The hardest situation to reach is an event pulse that lands in the very cycle its channel is being read. Only that overlap can lose an alarm, so the bench drives the read strobe and the event bit on the same falling edge. It then checks both the old word returned and the flag that survives. The bench also keeps several channels pending at once and reads them in a chosen order. This shows the line stays low after a partial clear and rises only after the full address sweep.

// File: rtl/par_irq_pkg.sv
package par_irq_pkg;

    localparam int REG_W     = 8;
    localparam int BIT_PFLAG = 0;
    localparam int BIT_PROV  = 1;
    localparam int BIT_PMASK = 2;
    localparam int BIT_OMASK = 3;
    localparam int BIT_LMASK = 4;
    localparam int BIT_OFLAG = 5;
    localparam int BIT_LFLAG = 6;

    typedef struct packed {
        logic prov;
        logic pmask;
        logic omask;
        logic lmask;
    } chan_cfg_t;

    typedef struct packed {
        logic pflag;
        logic oflag;
        logic lflag;
    } chan_flags_t;

    localparam chan_cfg_t   CFG_RESET   = '{prov: 1'b0, pmask: 1'b0, omask: 1'b1, lmask: 1'b1};
    localparam chan_flags_t FLAGS_RESET = '{pflag: 1'b0, oflag: 1'b0, lflag: 1'b0};

    function automatic chan_cfg_t cfg_from_bits(input logic prov, input logic pm,
                                                input logic om, input logic lm);
        chan_cfg_t c;
        c.prov  = prov;
        c.pmask = pm;
        c.omask = om;
        c.lmask = lm;
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input chan_cfg_t c, input chan_flags_t f);
        logic [REG_W-1:0] w;
        w            = '0;
        w[BIT_PFLAG] = f.pflag;
        w[BIT_PROV]  = c.prov;
        w[BIT_PMASK] = c.pmask;
        w[BIT_OMASK] = c.omask;
        w[BIT_LMASK] = c.lmask;
        w[BIT_OFLAG] = f.oflag;
        w[BIT_LFLAG] = f.lflag;
        return w;
    endfunction

    function automatic logic irq_term(input chan_cfg_t c, input chan_flags_t f);
        return c.prov & ((f.pflag & ~c.pmask) | (f.oflag & ~c.omask) | (f.lflag & ~c.lmask));
    endfunction

endpackage

// File: rtl/par_irq_chan.sv
module par_irq_chan
    import par_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             par_evt,
    input  logic             oof_evt,
    input  logic             los_evt,
    input  logic             sel_rd,
    input  logic             sel_wr,
    input  chan_cfg_t        cfg_in,
    output logic [REG_W-1:0] word,
    output logic             term,
    output logic             pflag,
    output logic             prov
);

    chan_cfg_t   cfg_q;
    chan_flags_t flg_q;
    chan_flags_t flg_d;

    // set beats clear so a coincident event is never lost
    always_comb begin
        flg_d.pflag = par_evt | (flg_q.pflag & ~sel_rd);
        flg_d.oflag = oof_evt | (flg_q.oflag & ~sel_rd);
        flg_d.lflag = los_evt | (flg_q.lflag & ~sel_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            flg_q <= FLAGS_RESET;
        end else begin
            flg_q <= flg_d;
            if (sel_wr) cfg_q <= cfg_in;
        end
    end

    assign word  = pack_word(cfg_q, flg_q);
    assign term  = irq_term(cfg_q, flg_q);
    assign pflag = flg_q.pflag;
    assign prov  = cfg_q.prov;

endmodule

// File: rtl/par_irq_rdmux.sv
module par_irq_rdmux
    import par_irq_pkg::*;
#(
    parameter int N_CH   = 64,
    parameter int ADDR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0] words [N_CH],
    output logic [REG_W-1:0] rd_data
);

    logic [REG_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (addr == ADDR_W'(i)) sel_word = words[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= sel_word;
    end

endmodule

// File: rtl/par_irq_combine.sv
module par_irq_combine #(
    parameter int N_CH = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] terms,
    output logic            irq_n
);

    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= ~(|terms);
    end

endmodule

// File: rtl/par_irq_agg.sv
module par_irq_agg
    import par_irq_pkg::*;
#(
    parameter int N_CH   = 64,
    localparam int ADDR_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   par_evt,
    input  logic [N_CH-1:0]   oof_evt,
    input  logic [N_CH-1:0]   los_evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_n
);

    logic [REG_W-1:0] words [N_CH];
    logic [N_CH-1:0]  terms;
    logic [N_CH-1:0]  pflag_vec;
    logic [N_CH-1:0]  prov_vec;
    chan_cfg_t        cfg_in;
    logic             unused_wd;

    assign cfg_in = cfg_from_bits(wr_data[BIT_PROV], wr_data[BIT_PMASK],
                                  wr_data[BIT_OMASK], wr_data[BIT_LMASK]);
    assign unused_wd = ^{wr_data[BIT_PFLAG], wr_data[BIT_OFLAG], wr_data[BIT_LFLAG], wr_data[7]};

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_chan
            par_irq_chan u_chan (
                .clk     (clk),
                .rst     (rst),
                .par_evt (par_evt[g]),
                .oof_evt (oof_evt[g]),
                .los_evt (los_evt[g]),
                .sel_rd  (rd_en && (addr == ADDR_W'(g))),
                .sel_wr  (wr_en && (addr == ADDR_W'(g))),
                .cfg_in  (cfg_in),
                .word    (words[g]),
                .term    (terms[g]),
                .pflag   (pflag_vec[g]),
                .prov    (prov_vec[g])
            );
        end
    endgenerate

    par_irq_rdmux #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_rdmux (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .addr    (addr),
        .words   (words),
        .rd_data (rd_data)
    );

    par_irq_combine #(.N_CH(N_CH)) u_combine (
        .clk   (clk),
        .rst   (rst),
        .terms (terms),
        .irq_n (irq_n)
    );

endmodule

// File: rtl/par_irq_agg_chk.sv
module par_irq_agg_chk #(
    parameter int N_CH   = 64,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [N_CH-1:0]   par_evt,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [7:0]        rd_data,
    input logic [N_CH-1:0]   pflag_vec,
    input logic [N_CH-1:0]   prov_vec,
    input logic              irq_n
);

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (|par_evt) |=> ((pflag_vec & $past(par_evt)) == $past(par_evt)));       // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !par_evt[addr]) |=> !pflag_vec[$past(addr)]);                  // R4

    AST_READ_DATA_FLAG: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rd_data[0] == $past(pflag_vec[addr])));                       // R4

    AST_WRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && !par_evt[addr]) |=> (pflag_vec[$past(addr)] == $past(pflag_vec[addr]))); // R5

    AST_UNPROV_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(prov_vec) == '0) |-> irq_n);                                      // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_en && par_evt[addr]) |=> pflag_vec[$past(addr)]);                    // R10

endmodule

bind par_irq_agg par_irq_agg_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .par_evt   (par_evt),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rd_data   (rd_data),
    .pflag_vec (pflag_vec),
    .prov_vec  (prov_vec),
    .irq_n     (irq_n)
);

// File: tb/par_irq_agg_test.sv
module par_irq_agg_test;

    localparam int N = 64;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  par_evt = '0;
    logic [N-1:0]  oof_evt = '0;
    logic [N-1:0]  los_evt = '0;
    logic [AW-1:0] addr = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          irq_n;

    int checks = 0;
    int errors = 0;

    par_irq_agg #(.N_CH(N)) uut (
        .clk(clk), .rst(rst), .par_evt(par_evt), .oof_evt(oof_evt), .los_evt(los_evt),
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    always #10 clk = ~clk;

    // op codes: 0 write, 1 parity pulse, 2 read+check, 3 irq check, 4 oof pulse, 5 los pulse
    // entry: {op[3:0], req[3:0], ch[7:0], wdata[7:0], expected[7:0]}
    localparam int NV = 30;
    localparam logic [31:0] VEC [NV] = '{
        {4'd2, 4'd1, 8'd5,  8'h00, 8'h18},  // R1 reset word
        {4'd3, 4'd1, 8'd0,  8'h00, 8'h01},  // R1 irq high
        {4'd1, 4'd2, 8'd5,  8'h00, 8'h00},
        {4'd3, 4'd7, 8'd0,  8'h00, 8'h01},  // R7 unprovisioned quiet
        {4'd2, 4'd2, 8'd5,  8'h00, 8'h19},  // R2 flag seen
        {4'd2, 4'd4, 8'd5,  8'h00, 8'h18},  // R4 cleared by read
        {4'd0, 4'd5, 8'd5,  8'h02, 8'h00},
        {4'd1, 4'd3, 8'd5,  8'h00, 8'h00},
        {4'd3, 4'd3, 8'd0,  8'h00, 8'h00},  // R3 irq low
        {4'd0, 4'd5, 8'd5,  8'h02, 8'h00},  // R5 write 0 into set flag
        {4'd3, 4'd5, 8'd0,  8'h00, 8'h00},
        {4'd2, 4'd5, 8'd5,  8'h00, 8'h03},  // R5 flag survived write
        {4'd3, 4'd9, 8'd0,  8'h00, 8'h01},  // R9 line released
        {4'd0, 4'd6, 8'd9,  8'h06, 8'h00},
        {4'd1, 4'd6, 8'd9,  8'h00, 8'h00},
        {4'd3, 4'd6, 8'd0,  8'h00, 8'h01},  // R6 masked parity quiet
        {4'd2, 4'd6, 8'd9,  8'h00, 8'h07},
        {4'd0, 4'd5, 8'd9,  8'h01, 8'h00},  // R5 write 1 to flag bit
        {4'd2, 4'd5, 8'd9,  8'h00, 8'h00},
        {4'd0, 4'd8, 8'd12, 8'h1A, 8'h00},
        {4'd4, 4'd8, 8'd12, 8'h00, 8'h00},
        {4'd3, 4'd8, 8'd0,  8'h00, 8'h01},  // R8 oof masked
        {4'd5, 4'd8, 8'd12, 8'h00, 8'h00},
        {4'd3, 4'd8, 8'd0,  8'h00, 8'h01},  // R8 los masked
        {4'd2, 4'd2, 8'd12, 8'h00, 8'h7A},  // R2 both alarm flags
        {4'd0, 4'd8, 8'd12, 8'h02, 8'h00},
        {4'd4, 4'd8, 8'd12, 8'h00, 8'h00},
        {4'd3, 4'd8, 8'd0,  8'h00, 8'h00},  // R8 oof unmasked interrupts
        {4'd2, 4'd4, 8'd12, 8'h00, 8'h22},
        {4'd3, 4'd9, 8'd0,  8'h00, 8'h01}   // R9
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int ch, input logic [7:0] d);
        @(negedge clk);
        addr = AW'(ch); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_pulse(input int kind, input int ch);
        @(negedge clk);
        if (kind == 1) par_evt[ch] = 1'b1;
        if (kind == 4) oof_evt[ch] = 1'b1;
        if (kind == 5) los_evt[ch] = 1'b1;
        @(negedge clk);
        par_evt = '0; oof_evt = '0; los_evt = '0;
    endtask

    task automatic do_read(input int ch, output logic [7:0] v);
        @(negedge clk);
        addr = AW'(ch); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    initial begin
        #3000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            int op, rq, ch;
            op = int'(VEC[i][31:28]);
            rq = int'(VEC[i][27:24]);
            ch = int'(VEC[i][23:16]);
            case (op)
                0: do_write(ch, VEC[i][15:8]);
                1, 4, 5: do_pulse(op, ch);
                2: begin
                    do_read(ch, v);
                    check(v == VEC[i][7:0], $sformatf("R%0d read row %0d", rq, i), int'(v), int'(VEC[i][7:0]));
                end
                default: begin
                    @(negedge clk);
                    check(irq_n == VEC[i][0], $sformatf("R%0d irq row %0d", rq, i), int'(irq_n), int'(VEC[i][0]));
                end
            endcase
        end

        // R10: event and read of the same channel in one cycle
        do_write(20, 8'h02);
        @(negedge clk);
        addr = AW'(20); rd_en = 1'b1; par_evt[20] = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; par_evt = '0;
        check(rd_data == 8'h02, "R10 old word", int'(rd_data), 8'h02);
        @(negedge clk);
        check(irq_n == 1'b0, "R10 flag kept", int'(irq_n), 0);
        do_read(20, v);
        check(v == 8'h03, "R10 flag readback", int'(v), 8'h03);
        @(negedge clk);
        check(irq_n == 1'b1, "R9 release after R10", int'(irq_n), 1);

        // R11: several pending channels, partial clear then full sweep
        do_write(3, 8'h02);
        do_write(40, 8'h02);
        do_write(63, 8'h02);
        @(negedge clk);
        par_evt[3] = 1'b1; par_evt[40] = 1'b1; par_evt[63] = 1'b1;
        @(negedge clk);
        par_evt = '0;
        @(negedge clk);
        check(irq_n == 1'b0, "R3 multi pending", int'(irq_n), 0);
        do_read(3, v);
        check(v == 8'h03, "R4 ch3 word", int'(v), 8'h03);
        @(negedge clk);
        check(irq_n == 1'b0, "R9 others pending", int'(irq_n), 0);
        for (int c = 0; c < N; c++) begin
            do_read(c, v);
            if (c == 40) check(v == 8'h03, "R11 ch40 word", int'(v), 8'h03);
            if (c == 63) check(v == 8'h03, "R11 ch63 word", int'(v), 8'h03);
        end
        @(negedge clk);
        check(irq_n == 1'b1, "R11 sweep restores line", int'(irq_n), 1);

        // R1: reset again restores defaults
        do_pulse(1, 40);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(irq_n == 1'b1, "R1 irq after reset", int'(irq_n), 1);
        do_read(40, v);
        check(v == 8'h18, "R1 word after reset", int'(v), 8'h18);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule